// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an incoming asynchronous serial line into bytes. It runs entirely on its own receive clock. It oversamples the line at a divide ratio of 1, 16 or 64, and software can change that ratio between frames. Each frame carries 7 or 8 data bits, least significant bit first. These may be followed by an even or odd parity bit, and then one or two stop bits.

The surrounding register interface supplies two control fields: a 4-bit word-format field and a 2-bit divide-select field. The block copies both fields when a start edge appears, so later changes do not affect a frame already in progress. A finished frame goes into a one-entry holding register, which raises a valid flag and carries framing and parity error flags for that byte. The register interface pulses `rd_ack`, on the receive clock, when it has taken the byte. If another frame finishes while the held byte is still unread, that frame is dropped and an overrun flag is raised.

Top module: `rx_deser`

## Requirements
- R1: While `rst` is high, and after it is released, `rx_valid`, `err_frame`, `err_parity` and `err_overrun` are 0 and `rx_byte` is 0x00 until the first frame completes.
- R2: `div_sel` 2'b00 selects divide-by-1: the line is low at edge t0, and data bit k is sampled at edge t0+1+k. 2'b01 selects divide-by-16 and 2'b10/2'b11 select divide-by-64. In those modes every bit after the start bit is sampled at the centre of its bit period.
- R3: In divide-by-16 and divide-by-64, the start bit is re-sampled half a bit period after the falling edge. If the line is high again at that point, the block returns to idle and delivers nothing.
- R4: `fmt[3]`=1 selects 8 data bits and `fmt[3]`=0 selects 7 data bits. Data arrives least significant bit first. For 7-bit words, `rx_byte[7]` is 0.
- R5: `fmt[2:1]` selects the parity mode: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 means no parity bit. On delivery, `err_parity` is 1 when the received parity bit does not match the selected mode.
- R6: `fmt[0]`=1 selects two stop bits and `fmt[0]`=0 selects one. `err_frame` is 1 for a byte whose first stop bit sampled low. The value of the second stop bit is ignored.
- R7: A completed frame sets `rx_valid`, and `rd_ack` clears it. If both happen in the same cycle, the new byte is delivered and `rx_valid` stays 1.
- R8: If a frame completes while `rx_valid` is 1 and `rd_ack` is 0, that frame is discarded. `rx_byte` keeps the older byte and `err_overrun` is set until the next `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial data line, idle high |
| fmt | input | 4 | Word format: {8-bit, parity mode[1:0], two stop bits} |
| div_sel | input | 2 | Clock divide select |
| rd_ack | input | 1 | Held byte taken by register interface |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | Held byte unread |
| err_frame | output | 1 | First stop bit of held byte was low |
| err_parity | output | 1 | Parity mismatch on held byte |
| err_overrun | output | 1 | A frame was dropped while a byte was unread |

## Verification
The bench sends 7-bit words whose top bit is set on the line. A receiver that samples one bit too many, or fails to clear its shift register, would report a 1 in bit 7. It sends a low pulse shorter than half a bit in divide-by-16 mode. A receiver without mid-bit start confirmation would deliver a byte of junk. It sends two unacknowledged frames back to back. Overwriting the held byte, or leaving `err_overrun` clear, are both caught. It also drives a low second stop bit and a corrupted parity bit, in both parity senses, so the bench sees whether the error flags are tied to the right bit positions.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        DIV_ONE  = 2'd0,
        DIV_MID  = 2'd1,
        DIV_HIGH = 2'd2
    } div_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_t;

    typedef struct packed {
        logic word8;
        par_t par;
        logic two_stop;
    } cfg_t;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_err;
        logic       parity_err;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } rx_state_t;

    function automatic cfg_t unpack_fmt(input logic [3:0] f);
        cfg_t c;
        c.word8    = f[3];
        c.par      = par_t'(f[2:1]);
        c.two_stop = f[0];
        return c;
    endfunction

    function automatic div_t decode_div(input logic [1:0] s);
        case (s)
            2'b00:   return DIV_ONE;
            2'b01:   return DIV_MID;
            default: return DIV_HIGH;
        endcase
    endfunction

    function automatic logic parity_on(input cfg_t c);
        return (c.par == PAR_EVEN) || (c.par == PAR_ODD);
    endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
    import rx_pkg::*;
#(
    parameter int MID_DIV  = 16,
    parameter int HIGH_DIV = 64,
    localparam int CNT_W   = $clog2(HIGH_DIV + 1)
) (
    input  logic clk,
    input  logic rst,
    input  div_t div,
    input  logic half,
    input  logic clr,
    output logic hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] target;

    always_comb begin
        case (div)
            DIV_ONE: ratio = ONE;
            DIV_MID: ratio = CNT_W'(MID_DIV);
            default: ratio = CNT_W'(HIGH_DIV);
        endcase
        target = half ? (ratio >> 1) : ratio;
        hit    = (cnt == target);
    end

    always_ff @(posedge clk) begin
        if (rst || clr || hit) cnt <= ONE;
        else                   cnt <= cnt + ONE;
    end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rxd,
    input  cfg_t   cfg_in,
    input  div_t   div_in,
    input  logic   hit,
    output logic   clr,
    output logic   half,
    output div_t   div_q,
    output cfg_t   cfg_q,
    output logic   done,
    output frame_t frame
);
    rx_state_t  st;
    logic [2:0] idx;
    logic [7:0] data;
    logic       acc;
    logic       pe;
    logic [2:0] last_idx;

    assign clr      = (st == ST_IDLE);
    assign half     = (st == ST_START);
    assign last_idx = cfg_q.word8 ? 3'd7 : 3'd6;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            idx   <= '0;
            data  <= '0;
            acc   <= 1'b0;
            pe    <= 1'b0;
            cfg_q <= '0;
            div_q <= DIV_ONE;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (!rxd) begin
                    cfg_q <= cfg_in;
                    div_q <= div_in;
                    data  <= '0;
                    acc   <= 1'b0;
                    idx   <= '0;
                    pe    <= 1'b0;
                    st    <= (div_in == DIV_ONE) ? ST_DATA : ST_START;
                end
                ST_START: if (hit) st <= rxd ? ST_IDLE : ST_DATA;
                ST_DATA: if (hit) begin
                    data[idx] <= rxd;
                    acc       <= acc ^ rxd;
                    idx       <= idx + 3'd1;
                    if (idx == last_idx)
                        st <= parity_on(cfg_q) ? ST_PAR : ST_STOP1;
                end
                ST_PAR: if (hit) begin
                    pe <= (acc ^ rxd) != (cfg_q.par == PAR_ODD);
                    st <= ST_STOP1;
                end
                ST_STOP1: if (hit) begin
                    frame <= '{data: data, frame_err: !rxd, parity_err: pe};
                    if (cfg_q.two_stop) begin
                        st <= ST_STOP2;
                    end else begin
                        done <= 1'b1;
                        st   <= ST_IDLE;
                    end
                end
                ST_STOP2: if (hit) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  frame_t     frame,
    input  logic       rd_ack,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte     <= '0;
            rx_valid    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (rd_ack) begin
                rx_valid    <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (done) begin
                if (rx_valid && !rd_ack) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_byte    <= frame.data;
                    rx_valid   <= 1'b1;
                    err_frame  <= frame.frame_err;
                    err_parity <= frame.parity_err;
                end
            end
        end
    end
endmodule

// File: rtl/rx_deser.sv
module rx_deser
    import rx_pkg::*;
#(
    parameter int MID_DIV  = 16,
    parameter int HIGH_DIV = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic [3:0] fmt,
    input  logic [1:0] div_sel,
    input  logic       rd_ack,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    logic   hit, clr, half, frm_done, cur_word8;
    div_t   div_q;
    cfg_t   cfg_q;
    frame_t frm;

    assign cur_word8 = cfg_q.word8;

    rx_bit_timer #(.MID_DIV(MID_DIV), .HIGH_DIV(HIGH_DIV)) u_timer (
        .clk(clk), .rst(rst), .div(div_q), .half(half), .clr(clr), .hit(hit)
    );

    rx_framer u_framer (
        .clk(clk), .rst(rst), .rxd(rxd),
        .cfg_in(unpack_fmt(fmt)), .div_in(decode_div(div_sel)),
        .hit(hit), .clr(clr), .half(half), .div_q(div_q), .cfg_q(cfg_q),
        .done(frm_done), .frame(frm)
    );

    rx_hold u_hold (
        .clk(clk), .rst(rst), .done(frm_done), .frame(frm), .rd_ack(rd_ack),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );
endmodule

// File: rtl/rx_deser_chk.sv
module rx_deser_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_ack,
    input logic       done,
    input logic       cur_word8,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun
);
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !done) |=> !rx_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !done) |=> !rx_valid);

    assert_overrun_keeps_byte_R8: assert property (@(posedge clk) disable iff (rst)
        (done && rx_valid && !rd_ack) |=> (err_overrun && rx_valid && $stable(rx_byte)));

    assert_short_word_msb_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !cur_word8 && (!rx_valid || rd_ack)) |=> !rx_byte[7]);

    assert_flags_only_on_delivery_R6: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(err_frame) && $stable(err_parity)));
endmodule

bind rx_deser rx_deser_chk u_chk (
    .clk(clk), .rst(rst), .rd_ack(rd_ack), .done(frm_done), .cur_word8(cur_word8),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
);

// File: tb/rx_deser_bench.sv
`timescale 1ns/1ps
module rx_deser_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [3:0] fmt = 4'b1000;
    logic [1:0] div_sel = 2'b01;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, err_frame, err_parity, err_overrun;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    always #4 clk = ~clk;

    rx_deser u_rx_deser (
        .clk(clk), .rst(rst), .rxd(rxd), .fmt(fmt), .div_sel(div_sel),
        .rd_ack(rd_ack), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int ratio);
        rxd = v;
        repeat (ratio) @(negedge clk);
    endtask

    // fmt: {8-bit, parity[1:0] (01 even, 10 odd), two stop}; div_sel 00=/1, 01=/16, 1x=/64
    task automatic send_frame(input logic [7:0] b, input logic [3:0] f, input logic [1:0] d,
                              input bit bad_par, input bit stop1_low, input bit stop2_low);
        int  ratio = (d == 2'b00) ? 1 : (d == 2'b01) ? 16 : 64;
        int  nbits = f[3] ? 8 : 7;
        logic p = 1'b0;
        @(negedge clk);
        fmt = f;
        div_sel = d;
        drive_bit(1'b0, ratio);
        for (int i = 0; i < nbits; i++) begin
            p ^= b[i];
            drive_bit(b[i], ratio);
        end
        if (f[2:1] == 2'b01 || f[2:1] == 2'b10) begin
            if (f[2:1] == 2'b10) p = ~p;
            drive_bit(p ^ bad_par, ratio);
        end
        drive_bit(~stop1_low, ratio);
        if (f[0]) drive_bit(~stop2_low, ratio);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] b,
                               input logic fe, input logic pe);
        check(req, "rx_valid", {7'd0, rx_valid}, 8'd1);
        check(req, "rx_byte", rx_byte, b);
        check(req, "err_frame", {7'd0, err_frame}, {7'd0, fe});
        check(req, "err_parity", {7'd0, err_parity}, {7'd0, pe});
    endtask

    task automatic t_reset();
        check("R1", "rx_valid", {7'd0, rx_valid}, 8'd0);
        check("R1", "rx_byte", rx_byte, 8'h00);
        check("R1", "errors", {5'd0, err_frame, err_parity, err_overrun}, 8'd0);
    endtask

    task automatic t_div16_8n1();
        send_frame(8'hA5, 4'b1000, 2'b01, 0, 0, 0);
        expect_byte("R2", 8'hA5, 0, 0);
        ack();
        check("R7", "rx_valid after ack", {7'd0, rx_valid}, 8'd0);
    endtask

    task automatic t_div64_8e1();
        send_frame(8'h3C, 4'b1010, 2'b10, 0, 0, 0);
        expect_byte("R5", 8'h3C, 0, 0);
        ack();
    endtask

    task automatic t_div1_7o2();
        send_frame(8'hD3, 4'b0101, 2'b00, 0, 0, 0);
        expect_byte("R4", 8'h53, 0, 0);
        ack();
    endtask

    task automatic t_parity_err();
        send_frame(8'h81, 4'b1010, 2'b01, 1, 0, 0);
        expect_byte("R5", 8'h81, 0, 1);
        ack();
        send_frame(8'h07, 4'b0100, 2'b00, 1, 0, 0);
        expect_byte("R5", 8'h07, 0, 1);
        ack();
    endtask

    task automatic t_framing();
        send_frame(8'h5A, 4'b1000, 2'b01, 0, 1, 0);
        expect_byte("R6", 8'h5A, 1, 0);
        ack();
        send_frame(8'hC3, 4'b1001, 2'b01, 0, 0, 1);
        expect_byte("R6", 8'hC3, 0, 0);
        ack();
    endtask

    task automatic t_glitch();
        @(negedge clk);
        div_sel = 2'b01;
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R3", "rx_valid after glitch", {7'd0, rx_valid}, 8'd0);
    endtask

    task automatic t_overrun();
        send_frame(8'h11, 4'b1000, 2'b01, 0, 0, 0);
        send_frame(8'h22, 4'b1000, 2'b01, 0, 0, 0);
        check("R8", "rx_byte kept", rx_byte, 8'h11);
        check("R8", "err_overrun", {7'd0, err_overrun}, 8'd1);
        ack();
        check("R8", "rx_valid after ack", {7'd0, rx_valid}, 8'd0);
        check("R8", "overrun cleared", {7'd0, err_overrun}, 8'd0);
    endtask

    task automatic t_back_to_back_div1();
        send_frame(8'hF0, 4'b1000, 2'b00, 0, 0, 0);
        expect_byte("R2", 8'hF0, 0, 0);
        ack();
        send_frame(8'h0F, 4'b1000, 2'b00, 0, 0, 0);
        expect_byte("R2", 8'h0F, 0, 0);
        ack();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_div16_8n1();
        t_div64_8e1();
        t_div1_7o2();
        t_parity_err();
        t_framing();
        t_glitch();
        t_overrun();
        t_back_to_back_div1();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule